// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block watches the two access ports of a shared two-port memory. It turns the two highest word addresses into mailboxes, one for each port. The second-highest address belongs to the left port and the highest address belongs to the right port. When one port writes into the other port's mailbox, the receiving port gets an active-low interrupt. The receiver clears that interrupt by reading its own mailbox. The mailbox bytes stay in the memory as ordinary data. The block only tracks the side effects of the accesses, so it has no data path.

Each port gives the block its chip enable, read/write, output enable, address and busy inputs, all active low except the address. When a port's busy input is asserted (low), that port's accesses cannot set or clear any flag. The flags are registered. A qualifying access seen at a clock edge changes the flag output from that edge onward.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both `left_irq_n` and `right_irq_n` become 1 (inactive) after that edge.
- R2: A right-port write (`r_ce_n`=0, `r_rw_n`=0) to address 2^ADDR_W-2 drives `left_irq_n` to 0 at the next edge.
- R3: A left-port write (`l_ce_n`=0, `l_rw_n`=0) to address 2^ADDR_W-1 drives `right_irq_n` to 0 at the next edge.
- R4: A left-port read (`l_ce_n`=0, `l_oe_n`=0) of address 2^ADDR_W-2 drives `left_irq_n` to 1 at the next edge. The value of `l_rw_n` has no effect on this clear.
- R5: A right-port read (`r_ce_n`=0, `r_oe_n`=0) of address 2^ADDR_W-1 drives `right_irq_n` to 1 at the next edge. The value of `r_rw_n` has no effect on this clear.
- R6: An access counts as a write only when chip enable and read/write are both 0. With either input at 1, no flag is set.
- R7: While a port's busy input is 0, that port's accesses neither set nor clear any flag.
- R8: If a set and a clear of the same flag happen in the same cycle, the flag is set (0).
- R9: Accesses to every other address leave both flags unchanged. A port writing its own mailbox does not set a flag, and a port reading the other port's mailbox does not clear one.
- R10: A port with chip enable 0 and output enable 1 does not clear its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write, 0 means write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_busy_n | input | 1 | Left busy, 0 blocks this port's flag actions |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write, 0 means write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_busy_n | input | 1 | Right busy, 0 blocks this port's flag actions |
| left_irq_n | output | 1 | Interrupt toward the left port, active low |
| right_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The bench builds the block with ADDR_W set to 6. This puts the mailboxes at addresses 62 and 63 and makes the whole address space 64 words, small enough to sweep completely. Every address is written and read from both ports, so the bench shows that only the two top words act as mailboxes and that the mailbox roles are not swapped between ports. The default 14-bit width shifts only the mailbox constants, which are derived from ADDR_W in the same way.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_PORTS = 2;

  // Decoded side effects of one port's access in the current cycle.
  typedef struct packed {
    logic set_peer;  // writes the mailbox owned by the opposite port
    logic clr_own;   // reads the mailbox owned by this port
  } mbx_hit_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int unsigned ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_ADDR = '1,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '0
) (
  input  logic              ce_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::mbx_hit_t hit
);
  logic wr_cyc;
  logic rd_cyc;

  // A write requires enable and write strobe; a read requires enable and
  // output enable, whatever the write strobe is doing.
  assign wr_cyc = !ce_n && !rw_n && busy_n;
  assign rd_cyc = !ce_n && !oe_n && busy_n;

  always_comb begin
    hit.set_peer = wr_cyc && (addr == PEER_ADDR);
    hit.clr_own  = rd_cyc && (addr == OWN_ADDR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_n_o <= 1'b1;
    else if (set_i) irq_n_o <= 1'b0;
    else if (clr_i) irq_n_o <= 1'b1;
  end

  // R8: a set in the same cycle as a clear still lands
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !irq_n_o);
  // R4 / R5: a lone clear releases the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> irq_n_o);
  // R9: with no action the flag holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              left_irq_n,
  output logic              right_irq_n
);
  import mbx_pkg::*;

  // Port 0 (left) owns the second-highest word, port 1 (right) the highest.
  localparam logic [ADDR_W-1:0] MBOX_BASE = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic              ce_n   [NUM_PORTS];
  logic              rw_n   [NUM_PORTS];
  logic              oe_n   [NUM_PORTS];
  logic              busy_n [NUM_PORTS];
  logic [ADDR_W-1:0] addr   [NUM_PORTS];
  mbx_hit_t          hit    [NUM_PORTS];
  logic              irq_n  [NUM_PORTS];

  assign ce_n[0]   = l_ce_n;
  assign rw_n[0]   = l_rw_n;
  assign oe_n[0]   = l_oe_n;
  assign busy_n[0] = l_busy_n;
  assign addr[0]   = l_addr;
  assign ce_n[1]   = r_ce_n;
  assign rw_n[1]   = r_rw_n;
  assign oe_n[1]   = r_oe_n;
  assign busy_n[1] = r_busy_n;
  assign addr[1]   = r_addr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = MBOX_BASE + ADDR_W'(p);
    localparam logic [ADDR_W-1:0] PEER = MBOX_BASE + ADDR_W'(NUM_PORTS - 1 - p);

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) u_dec (
      .ce_n  (ce_n[p]),
      .rw_n  (rw_n[p]),
      .oe_n  (oe_n[p]),
      .busy_n(busy_n[p]),
      .addr  (addr[p]),
      .hit   (hit[p])
    );

    // Flag p is raised by the opposite port and released by its owner.
    mbx_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (hit[NUM_PORTS-1-p].set_peer),
      .clr_i  (hit[p].clr_own),
      .irq_n_o(irq_n[p])
    );
  end

  assign left_irq_n  = irq_n[0];
  assign right_irq_n = irq_n[1];

  // R1: reset returns both flags to inactive
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (left_irq_n && right_irq_n));
  // R7: a busy right port cannot raise the left flag
  p_busy_noset_r7: assert property (@(posedge clk) disable iff (rst)
    (!r_busy_n && left_irq_n) |=> left_irq_n);
  // R7: a busy left port cannot release its own flag
  p_busy_noclr_r7: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n && !left_irq_n) |=> !left_irq_n);
  // R7: a busy left port cannot raise the right flag
  p_busy_noset_r_r7: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n && right_irq_n) |=> right_irq_n);
endmodule

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;
  localparam int unsigned AW = 6;
  localparam int unsigned LM = (1 << AW) - 2;
  localparam int unsigned RM = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
  logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic left_irq_n, right_irq_n;

  always #5 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .left_irq_n(left_irq_n), .right_irq_n(right_irq_n)
  );

  typedef struct {
    logic  l;
    logic  r;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic m_l = 1'b1;
  logic m_r = 1'b1;
  bit   done = 0;

  task automatic check(input logic l, input logic r, input string tag);
    n_chk++;
    if (left_irq_n !== l || right_irq_n !== r) begin
      n_bad++;
      $display("FAIL %s: left/right irq actual %b/%b expected %b/%b",
               tag, left_irq_n, right_irq_n, l, r);
    end
  endtask

  // Driver: present one cycle of stimulus and queue the expected flags.
  task automatic drv(input logic lce, input logic lrw, input logic loe, input int la, input logic lb,
                     input logic rce, input logic rrw, input logic roe, input int ra, input logic rb,
                     input logic rs, input string tag);
    logic nl, nr;
    @(negedge clk);
    rst = rs;
    l_ce_n = lce; l_rw_n = lrw; l_oe_n = loe; l_addr = AW'(la); l_busy_n = lb;
    r_ce_n = rce; r_rw_n = rrw; r_oe_n = roe; r_addr = AW'(ra); r_busy_n = rb;
    nl = m_l; nr = m_r;
    if (rs) begin
      nl = 1'b1; nr = 1'b1;
    end else begin
      if (!lce && !loe && lb && la == LM) nl = 1'b1;
      if (!rce && !rrw && rb && ra == LM) nl = 1'b0;
      if (!rce && !roe && rb && ra == RM) nr = 1'b1;
      if (!lce && !lrw && lb && la == RM) nr = 1'b0;
    end
    m_l = nl; m_r = nr;
    q.push_back('{l: nl, r: nr, tag: tag});
  endtask

  task automatic lwr(input int a, input string tag);
    drv(0, 0, 1, a, 1, 1, 1, 1, 0, 1, 0, tag);
  endtask
  task automatic rwr(input int a, input string tag);
    drv(1, 1, 1, 0, 1, 0, 0, 1, a, 1, 0, tag);
  endtask
  task automatic lrd(input int a, input string tag);
    drv(0, 1, 0, a, 1, 1, 1, 1, 0, 1, 0, tag);
  endtask
  task automatic rrd(input int a, input string tag);
    drv(1, 1, 1, 0, 1, 0, 1, 0, a, 1, 0, tag);
  endtask
  task automatic idle(input string tag);
    drv(1, 1, 1, 0, 1, 1, 1, 1, 0, 1, 0, tag);
  endtask

  // Monitor: compare queued expectations just after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.l, e.r, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(1'b1, 1'b1, "R1 reset state");

    rwr(LM, "R2 right writes left mailbox");
    lrd(LM, "R4 left reads own mailbox");
    lwr(RM, "R3 left writes right mailbox");
    rrd(RM, "R5 right reads own mailbox");

    // R6: write needs both strobes
    drv(1, 1, 1, 0, 1, 1, 0, 1, LM, 1, 0, "R6 ce high no set");
    drv(1, 1, 1, 0, 1, 0, 1, 1, LM, 1, 0, "R6 rw high no set");
    drv(1, 0, 1, RM, 1, 1, 1, 1, 0, 1, 0, "R6 left ce high no set");

    // R7: busy suppresses set and clear
    drv(1, 1, 1, 0, 1, 0, 0, 1, LM, 0, 0, "R7 busy right blocks set");
    rwr(LM, "R7 set with busy clear");
    drv(0, 1, 0, LM, 0, 1, 1, 1, 0, 1, 0, "R7 busy left blocks clear");
    drv(0, 0, 1, RM, 0, 1, 1, 1, 0, 1, 0, "R7 busy left blocks right set");
    lrd(LM, "R7 clear after busy");

    // R8: simultaneous set and clear
    drv(0, 1, 0, LM, 1, 0, 0, 1, LM, 1, 0, "R8 set wins over clear left");
    drv(0, 0, 1, RM, 1, 0, 1, 0, RM, 1, 0, "R8 set wins over clear right");
    lrd(LM, "R8 release left");
    rrd(RM, "R8 release right");

    // R10 and R4 rw independence
    rwr(LM, "R10 setup");
    drv(0, 1, 1, LM, 1, 1, 1, 1, 0, 1, 0, "R10 oe high no clear");
    drv(0, 0, 0, LM, 1, 1, 1, 1, 0, 1, 0, "R4 clear with rw low");
    lwr(RM, "R10 setup right");
    drv(1, 1, 1, 0, 1, 0, 1, 1, RM, 1, 0, "R10 right oe high no clear");
    drv(1, 1, 1, 0, 1, 0, 0, 0, RM, 1, 0, "R5 clear with rw low");

    // R9: wrong-direction mailbox accesses
    lwr(LM, "R9 left writes own mailbox");
    rwr(RM, "R9 right writes own mailbox");
    rwr(LM, "R9 setup left");
    lwr(RM, "R9 setup right");
    rrd(LM, "R9 right reads left mailbox");
    lrd(RM, "R9 left reads right mailbox");
    idle("R9 idle hold");
    lrd(LM, "R9 release left");
    rrd(RM, "R9 release right");

    // R9: full address sweep from both ports
    for (int a = 0; a < (1 << AW); a++) begin
      drv(0, 0, 1, a, 1, 0, 0, 1, a, 1, 0, "R9 write sweep");
    end
    for (int a = 0; a < (1 << AW); a++) begin
      drv(0, 1, 0, a, 1, 0, 1, 0, (1 << AW) - 1 - a, 1, 0, "R9 read sweep");
    end

    // R1: reset in the middle of activity
    rwr(LM, "R1 setup");
    lwr(RM, "R1 setup");
    drv(1, 1, 1, 0, 1, 1, 1, 1, 0, 1, 1, "R1 mid-run reset");
    idle("R1 after reset");

    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule